// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces indirect operand addresses for a datapath that fetches from memory. It keeps four pointer registers, four modify registers and four length registers. When the access strobe is raised, the block issues the selected pointer as the address and then advances that pointer by a signed step taken from any of the four modify registers. If the pointer's length register is non-zero, the advance wraps inside a circular buffer. That buffer starts at the value last written into the pointer.

Software-visible state is loaded through one write port. A kind code on that port picks the register family, and a 2-bit select picks the register within it. A datapath that fetches two operands in the same cycle places two instances side by side, one for each memory.

Top module: `circ_agu`

## Requirements
- R1: One cycle after a cycle with `accEn` high, `addrValid` is high and `addrOut` equals the value the pointer chosen by `idxSel` held before the access. After a cycle with `accEn` low, `addrValid` is low.
- R2: After an access, the chosen pointer has moved by the modify register chosen by `modSel`, read as a signed two's-complement value of `ADDR_W` bits.
- R3: With `wrEn` high, `wrKind` selects the target family and `wrSel` selects the register: 0 is pointer, 1 is modify, 2 is length. The written value is used from the next cycle on.
- R4: A length of 0 makes the advance linear, and the pointer wraps modulo 2^ADDR_W.
- R5: With length L non-zero and base B, an advanced value at or above B+L is reduced by L.
- R6: With length L non-zero and base B, an advanced value below B is increased by L.
- R7: Writing a pointer also sets that pointer's base to the written value.
- R8: If a pointer write and an access to the same pointer fall in the same cycle, the write wins and no advance happens. The issued address is still the value the pointer held before that cycle.
- R9: An access changes no pointer other than the one selected.
- R10: A write with `wrKind` = 3 changes no register.
- R11: After reset, all registers are zero, `addrValid` is low and `addrOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Access strobe |
| idxSel | input | 2 | Pointer used by the access |
| modSel | input | 2 | Modify register used by the access |
| wrEn | input | 1 | Register write enable |
| wrKind | input | 2 | Write target family: 0 pointer, 1 modify, 2 length, 3 none |
| wrSel | input | 2 | Register within the family |
| wrData | input | ADDR_W | Write value |
| addrOut | output | ADDR_W | Issued address |
| addrValid | output | 1 | addrOut holds a fresh address |

## Verification
Every issued address appears exactly one clock after its access strobe. A register write becomes visible to the first access in a later cycle. The driver presents each stimulus just after a falling edge and computes the expected address from its own copy of the register state. It then queues that address. The monitor samples shortly after each rising edge and pops one queued address for every cycle with `addrValid` high, so each result is compared in the single cycle it is due.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int NUM_REG = 4;
  localparam int SEL_W   = $clog2(NUM_REG);

  typedef enum logic [1:0] {
    WR_INDEX  = 2'd0,
    WR_MODIFY = 2'd1,
    WR_LENGTH = 2'd2,
    WR_NONE   = 2'd3
  } wrKind_e;

  typedef struct packed {
    logic               access;
    logic               postMod;
    logic [SEL_W-1:0]   ptrSel;
    logic [SEL_W-1:0]   modSel;
    logic [NUM_REG-1:0] wrIdx;
    logic [NUM_REG-1:0] wrMod;
    logic [NUM_REG-1:0] wrLen;
  } aguStrobe_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic             accEn,
  input  logic [SEL_W-1:0] idxSel,
  input  logic [SEL_W-1:0] modSel,
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic [SEL_W-1:0] wrSel,
  output aguStrobe_t       strobe
);
  logic [NUM_REG-1:0] idxHit, modHit, lenHit;

  always_comb begin
    for (int i = 0; i < NUM_REG; i++) begin
      idxHit[i] = wrEn && (wrKind == WR_INDEX)  && (wrSel == SEL_W'(i));
      modHit[i] = wrEn && (wrKind == WR_MODIFY) && (wrSel == SEL_W'(i));
      lenHit[i] = wrEn && (wrKind == WR_LENGTH) && (wrSel == SEL_W'(i));
    end
  end

  // R8: a pointer write in the same cycle suppresses the post-modify
  always_comb begin
    strobe.access  = accEn;
    strobe.postMod = accEn && !idxHit[idxSel];
    strobe.ptrSel  = idxSel;
    strobe.modSel  = modSel;
    strobe.wrIdx   = idxHit;
    strobe.wrMod   = modHit;
    strobe.wrLen   = lenHit;
  end
endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid
);
  localparam int EXT_W = ADDR_W + 2;

  logic [ADDR_W-1:0] ptrReg  [NUM_REG];
  logic [ADDR_W-1:0] baseReg [NUM_REG];
  logic [ADDR_W-1:0] modReg  [NUM_REG];
  logic [ADDR_W-1:0] lenReg  [NUM_REG];

  logic [ADDR_W-1:0] curPtr, curMod, curBase, curLen, nextPtr;
  logic signed [EXT_W-1:0] sumX, baseX, lenX, endX;

  assign curPtr  = ptrReg[strobe.ptrSel];
  assign curBase = baseReg[strobe.ptrSel];
  assign curLen  = lenReg[strobe.ptrSel];
  assign curMod  = modReg[strobe.modSel];

  always_comb begin
    baseX = signed'({2'b00, curBase});
    lenX  = signed'({2'b00, curLen});
    endX  = baseX + lenX;
    sumX  = signed'({2'b00, curPtr}) + signed'({{2{curMod[ADDR_W-1]}}, curMod});
    if (curLen == '0)         nextPtr = sumX[ADDR_W-1:0];
    else if (sumX >= endX)    nextPtr = ADDR_W'(sumX - lenX);
    else if (sumX < baseX)    nextPtr = ADDR_W'(sumX + lenX);
    else                      nextPtr = sumX[ADDR_W-1:0];
  end

  // range check helpers for assertions
  logic [ADDR_W-1:0] absMod;
  logic              modSmall;
  assign absMod   = curMod[ADDR_W-1] ? ADDR_W'(-curMod) : curMod;
  assign modSmall = absMod < curLen;

  generate
    for (genvar g = 0; g < NUM_REG; g++) begin : gReg
      logic [EXT_W-1:0] bufEnd;
      logic             inBuf;
      assign bufEnd = {2'b00, baseReg[g]} + {2'b00, lenReg[g]};
      assign inBuf  = (lenReg[g] != '0) && (bufEnd <= EXT_W'(2**ADDR_W)) &&
                      (ptrReg[g] >= baseReg[g]) && ({2'b00, ptrReg[g]} < bufEnd);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ptrReg[g]  <= '0;
          baseReg[g] <= '0;
          modReg[g]  <= '0;
          lenReg[g]  <= '0;
        end else begin
          if (strobe.wrIdx[g]) begin
            ptrReg[g]  <= wrData;
            baseReg[g] <= wrData;
          end else if (strobe.postMod && strobe.ptrSel == SEL_W'(g)) begin
            ptrReg[g] <= nextPtr;
          end
          if (strobe.wrMod[g]) modReg[g] <= wrData;
          if (strobe.wrLen[g]) lenReg[g] <= wrData;
        end
      end

      p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrIdx[g] |=> (ptrReg[g] == $past(wrData)) && (baseReg[g] == $past(wrData)));

      p_other_ptr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.wrIdx[g] && !(strobe.access && strobe.ptrSel == SEL_W'(g)))
        |=> $stable(ptrReg[g]));

      // R5 / R6: a pointer inside its buffer stays inside after a small step
      p_stay_in_buffer_r5: assert property (@(posedge clk) disable iff (!rstN)
        (inBuf && strobe.postMod && strobe.ptrSel == SEL_W'(g) && modSmall &&
         !strobe.wrLen[g]) |=> inBuf);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut   <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= strobe.access;
      if (strobe.access) addrOut <= curPtr;
    end
  end

  p_issue_old_ptr_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.access |=> addrValid && (addrOut == $past(curPtr)));

  p_idle_no_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.access |=> !addrValid);
endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accEn,
  input  logic [1:0]        idxSel,
  input  logic [1:0]        modSel,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid
);
  aguStrobe_t strobe;

  agu_ctrl u_ctrl (
    .accEn  (accEn),
    .idxSel (idxSel),
    .modSel (modSel),
    .wrEn   (wrEn),
    .wrKind (wrKind),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  agu_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .addrOut   (addrOut),
    .addrValid (addrValid)
  );
endmodule

// File: tb/sim_circ_agu.sv
`timescale 1ns/100ps
module sim_circ_agu;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         accEn = 1'b0;
  logic [1:0]   idxSel = '0, modSel = '0, wrKind = '0, wrSel = '0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] addrOut;
  logic         addrValid;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] expQ[$];
  string        tagQ[$];

  // bench copy of the architectural state
  logic [W-1:0] mPtr[4], mBase[4], mMod[4], mLen[4];

  circ_agu #(.ADDR_W(W)) u0 (
    .clk(clk), .rstN(rstN), .accEn(accEn), .idxSel(idxSel), .modSel(modSel),
    .wrEn(wrEn), .wrKind(wrKind), .wrSel(wrSel), .wrData(wrData),
    .addrOut(addrOut), .addrValid(addrValid)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] stepPtr(input int p, input int m);
    int s, b, l;
    b = int'(mBase[p]);
    l = int'(mLen[p]);
    s = int'(mPtr[p]) + (mMod[m][W-1] ? int'(mMod[m]) - (1 << W) : int'(mMod[m]));
    if (l != 0) begin
      if (s >= b + l)  s = s - l;
      else if (s < b)  s = s + l;
    end
    return W'(s);
  endfunction

  task automatic idle();
    @(negedge clk);
    accEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] kind, input logic [1:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    accEn = 1'b0; wrEn = 1'b1; wrKind = kind; wrSel = sel; wrData = data;
    case (kind)
      2'd0: begin mPtr[sel] = data; mBase[sel] = data; end
      2'd1: mMod[sel] = data;
      2'd2: mLen[sel] = data;
      default: ;
    endcase
  endtask

  task automatic doAccess(input logic [1:0] p, input logic [1:0] m, input string tag);
    @(negedge clk);
    wrEn = 1'b0; accEn = 1'b1; idxSel = p; modSel = m;
    expQ.push_back(mPtr[p]);
    tagQ.push_back(tag);
    mPtr[p] = stepPtr(p, m);
  endtask

  // access and pointer write to the same pointer in one cycle
  task automatic doAccWr(input logic [1:0] p, input logic [1:0] m, input logic [W-1:0] data);
    @(negedge clk);
    accEn = 1'b1; idxSel = p; modSel = m;
    wrEn = 1'b1; wrKind = 2'd0; wrSel = p; wrData = data;
    expQ.push_back(mPtr[p]);
    tagQ.push_back("R8 issued");
    mPtr[p] = data; mBase[p] = data;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rstN && addrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected valid", int'(addrOut), -1);
      end else begin
        logic [W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(addrOut == e, t, int'(addrOut), int'(e));
      end
    end
  end

  task automatic finishSim();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    check(1'b0, "watchdog", 0, 1);
    finishSim();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mPtr[i] = '0; mBase[i] = '0; mMod[i] = '0; mLen[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(addrValid == 1'b0, "R11 valid after reset", int'(addrValid), 0);
    check(addrOut == '0, "R11 addr after reset", int'(addrOut), 0);

    // R11: registers cleared, step of zero leaves pointer at zero
    doAccess(2'd0, 2'd0, "R11 zero pointer");
    doAccess(2'd0, 2'd0, "R11 zero pointer again");
    idle();
    @(posedge clk); #1;
    check(addrValid == 1'b0, "R1 idle clears valid", int'(addrValid), 0);

    // R2/R3/R4 linear stepping
    doWrite(2'd0, 2'd0, 14'd100);
    doWrite(2'd1, 2'd0, 14'd3);
    doAccess(2'd0, 2'd0, "R3 R1 first");
    doAccess(2'd0, 2'd0, "R2 step +3");
    doAccess(2'd0, 2'd0, "R2 step +3 again");

    // R4 linear wrap at top of space
    doWrite(2'd0, 2'd1, 14'd16382);
    doAccess(2'd1, 2'd0, "R4 near top");
    doAccess(2'd1, 2'd0, "R4 wrapped");

    // R5/R6/R7 circular buffer base 200 length 10
    doWrite(2'd0, 2'd2, 14'd200);
    doWrite(2'd2, 2'd2, 14'd10);
    doWrite(2'd1, 2'd2, 14'd4);
    doWrite(2'd1, 2'd3, 14'(-3));
    doAccess(2'd2, 2'd2, "R7 base");
    doAccess(2'd2, 2'd2, "R5 204");
    doAccess(2'd2, 2'd2, "R5 208");
    doAccess(2'd2, 2'd3, "R5 wrapped down 202");
    doAccess(2'd2, 2'd3, "R6 199 raised 209");
    doAccess(2'd2, 2'd2, "R5 after raise");

    // R9: pointer 0 untouched by pointer 2 accesses
    doAccess(2'd0, 2'd1, "R9 ptr0 unchanged");

    // R8: write wins over same-pointer access
    doAccWr(2'd2, 2'd2, 14'd300);
    doAccess(2'd2, 2'd2, "R8 written value");

    // R10: kind 3 writes nothing
    doWrite(2'd3, 2'd0, 14'd5);
    doAccess(2'd0, 2'd0, "R10 ignored write");
    doWrite(2'd3, 2'd2, 14'd7);
    doAccess(2'd2, 2'd2, "R10 modify kept");

    idle();
    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R1 all results seen", expQ.size(), 0);
    finishSim();
  end
endmodule